// File: doc/BRIEF.md
# External Bus Wait-State Sequencer

This block runs one external bus access at a time, either a read or a write, and decides how many bus-clock cycles it lasts. A requester raises `req` with a direction flag and a 3-bit wait setting while the sequencer is idle. The sequencer then drives the matching active-low strobe for the length of the access. It reports the current cycle number and whether that cycle is an inserted wait cycle. In the final cycle it raises `done` for one cycle.

Reads and writes count waits differently. A read lasts one cycle plus the programmed waits. A write never lasts fewer than two cycles, so one programmed wait does not lengthen it. When the programmed count is used up, an active-low external wait pin can hold the access for as long as needed. A read finishes in the cycle in which the pin is seen released. A write finishes one cycle after that.

Top module: `bws_seq`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle is idle: `rd_n` and `wr_n` are 1, `done` is 0, `cyc_num` is 0 and `in_wait` is 0.
- R2: A read (`req_write`=0) with programmed wait count WC and `ext_wait_n` high from cycle 1+WC onward lasts exactly 1+WC cycles.
- R3: A write (`req_write`=1) with programmed wait count WC and `ext_wait_n` high from the programmed end onward lasts max(2, 1+WC) cycles. WC=0 and WC=1 both give 2 cycles.
- R4: For a read, if `ext_wait_n` is 0 in cycle P=1+WC and stays 0 for H cycles, the read ends in cycle P+H, which is the first cycle in which the pin is 1.
- R5: For a write with programmed length P, if `ext_wait_n` is 0 in cycle P and stays 0 for H≥1 cycles, the write ends in cycle P+H+1, one cycle after the pin is first seen at 1. The pin has no effect in that final cycle.
- R6: The level of `ext_wait_n` in cycles before the programmed length is reached does not change the length of an access.
- R7: `done` is 1 in exactly one cycle per access, the last one, and is 0 in idle.
- R8: `rd_n` (read) or `wr_n` (write) is 0 in every cycle from cycle 1 to the last cycle, and is 1 in the idle cycle that follows. The two strobes are never 0 together.
- R9: A request is taken only in idle. The cycle after an accepted request is cycle 1. `req`, `req_write` and `wait_cfg` have no effect while an access is running.
- R10: `cyc_num` counts 1, 2, 3 … through the access, saturating at its maximum. `in_wait` is 1 exactly in the cycles numbered above 1 for a read and above 2 for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising-edge active |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request, taken only in idle |
| req_write | input | 1 | 1 = write, 0 = read; captured with `req` |
| wait_cfg | input | WC_W (3) | Programmed wait cycles 0..7; captured with `req` |
| ext_wait_n | input | 1 | External wait, active low, honoured after the programmed count |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| cyc_num | output | CNT_W (8) | Current cycle number of the access, 0 in idle |
| in_wait | output | 1 | Current cycle is an inserted wait cycle |
| done | output | 1 | One-cycle pulse in the last cycle of the access |

## Verification
The bench targets write accesses with wait settings of 0 and 1. A design that lets a single wait lengthen a write gives three cycles there instead of two. It checks the end of an externally stretched access in both directions. A design that treats writes like reads would end them one cycle early, and one that treats reads like writes would stretch them one cycle too long. It drives noise on the wait pin before the programmed count runs out, which a design that samples the pin too early would turn into extra cycles. It also changes the request, direction and wait inputs in mid-access, which a design that does not capture them would pick up as a new length or a double access.

// File: rtl/bws_pkg.sv
`timescale 1ns/1ps
package bws_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_TAIL = 2'd2
    } seq_state_t;

    // Number of cycles a write spans even with no programmed wait.
    localparam int WR_FLOOR = 2;
    // Number of cycles a read spans with no programmed wait.
    localparam int RD_FLOOR = 1;

endpackage

// File: rtl/bws_plen.sv
`timescale 1ns/1ps
// Programmed access length and base (non-wait) length for the captured settings.
module bws_plen #(
    parameter int WC_W  = 3,
    parameter int CNT_W = 8
) (
    input  logic [WC_W-1:0]  wc,
    input  logic             is_wr,
    output logic [CNT_W-1:0] plen,
    output logic [CNT_W-1:0] base
);
    import bws_pkg::*;

    localparam logic [CNT_W-1:0] RD_BASE = CNT_W'(RD_FLOOR);
    localparam logic [CNT_W-1:0] WR_BASE = CNT_W'(WR_FLOOR);

    logic [CNT_W-1:0] raw_len;

    always_comb begin
        raw_len = CNT_W'(wc) + RD_BASE;
        if (is_wr) begin
            base = WR_BASE;
            plen = (raw_len < WR_BASE) ? WR_BASE : raw_len;
        end else begin
            base = RD_BASE;
            plen = raw_len;
        end
    end

endmodule

// File: rtl/bws_endchk.sv
`timescale 1ns/1ps
// Decides, for the running cycle, whether the access ends or moves to the write tail.
module bws_endchk #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] plen,
    input  logic             is_wr,
    input  logic             stretched,
    input  logic             ext_wait_n,
    output logic             at_end,
    output logic             finish,
    output logic             to_tail,
    output logic             hold
);
    always_comb begin
        at_end  = (cnt >= plen);
        hold    = at_end && !ext_wait_n;
        finish  = at_end && ext_wait_n && (!is_wr || !stretched);
        to_tail = at_end && ext_wait_n && is_wr && stretched;
    end

endmodule

// File: rtl/bws_seq.sv
`timescale 1ns/1ps
module bws_seq #(
    parameter int WC_W  = 3,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic             req_write,
    input  logic [WC_W-1:0]  wait_cfg,
    input  logic             ext_wait_n,
    output logic             rd_n,
    output logic             wr_n,
    output logic [CNT_W-1:0] cyc_num,
    output logic             in_wait,
    output logic             done
);
    import bws_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    typedef struct packed {
        seq_state_t       st;
        logic             is_wr;
        logic [WC_W-1:0]  wc;
        logic [CNT_W-1:0] cnt;
        logic             stretched;
    } seq_regs_t;

    seq_regs_t q, d;

    logic [CNT_W-1:0] plen;
    logic [CNT_W-1:0] base;
    logic             at_end;
    logic             fin_run;
    logic             go_tail;
    logic             hold_run;
    logic             busy;
    logic [CNT_W-1:0] cnt_inc;

    bws_plen #(.WC_W(WC_W), .CNT_W(CNT_W)) u_plen (
        .wc    (q.wc),
        .is_wr (q.is_wr),
        .plen  (plen),
        .base  (base)
    );

    bws_endchk #(.CNT_W(CNT_W)) u_end (
        .cnt        (q.cnt),
        .plen       (plen),
        .is_wr      (q.is_wr),
        .stretched  (q.stretched),
        .ext_wait_n (ext_wait_n),
        .at_end     (at_end),
        .finish     (fin_run),
        .to_tail    (go_tail),
        .hold       (hold_run)
    );

    assign busy    = (q.st != ST_IDLE);
    assign cnt_inc = (q.cnt == CNT_MAX) ? CNT_MAX : q.cnt + CNT_ONE;

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                d.cnt       = '0;
                d.stretched = 1'b0;
                if (req) begin
                    d.st    = ST_RUN;
                    d.is_wr = req_write;
                    d.wc    = wait_cfg;
                    d.cnt   = CNT_ONE;
                end
            end
            ST_RUN: begin
                if (fin_run) begin
                    d.st  = ST_IDLE;
                    d.cnt = '0;
                end else begin
                    d.cnt = cnt_inc;
                    if (go_tail) begin
                        d.st = ST_TAIL;
                    end
                    if (hold_run) begin
                        d.stretched = 1'b1;
                    end
                end
            end
            ST_TAIL: begin
                d.st        = ST_IDLE;
                d.cnt       = '0;
                d.stretched = 1'b0;
            end
            default: begin
                d.st  = ST_IDLE;
                d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q.st        <= ST_IDLE;
            q.is_wr     <= 1'b0;
            q.wc        <= '0;
            q.cnt       <= '0;
            q.stretched <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign rd_n    = !(busy && !q.is_wr);
    assign wr_n    = !(busy && q.is_wr);
    assign cyc_num = q.cnt;
    assign in_wait = busy && (q.cnt > base);
    assign done    = (q.st == ST_TAIL) || ((q.st == ST_RUN) && fin_run);

    // Captured wait setting, exposed for the bound checker.
    logic [WC_W-1:0] wc_lat;
    assign wc_lat = q.wc;

endmodule

// File: rtl/bws_seq_chk.sv
`timescale 1ns/1ps
module bws_seq_chk #(
    parameter int WC_W  = 3,
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             req,
    input logic             rd_n,
    input logic             wr_n,
    input logic [CNT_W-1:0] cyc_num,
    input logic             in_wait,
    input logic             done,
    input logic [WC_W-1:0]  wc_lat
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             active;
    logic [CNT_W-1:0] min_len;

    assign active  = !rd_n || !wr_n;
    assign min_len = (!wr_n && wc_lat == '0) ? CNT_W'(2) : CNT_W'(wc_lat) + CNT_W'(1);

    // R1: reset leaves the bus idle
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (rd_n && wr_n && !done && cyc_num == '0 && !in_wait));

    // R6: no completion before the programmed length
    p_no_early_end_r6: assert property (@(posedge clk) disable iff (rst)
        (active && cyc_num < min_len) |-> !done);

    // R7: done is a single-cycle pulse and never seen in idle
    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_busy_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> active);

    // R8: strobes exclusive, released after the last cycle
    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(!rd_n && !wr_n));
    p_release_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> (rd_n && wr_n));

    // R9: an idle request starts cycle 1; the direction holds during an access
    p_start_r9: assert property (@(posedge clk) disable iff (rst)
        (!active && req) |=> (cyc_num == 1));
    p_dir_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (active && !done) |=> ($stable(rd_n) && $stable(wr_n)));

    // R10: cycle number advances by one until the access ends
    p_count_step_r10: assert property (@(posedge clk) disable iff (rst)
        (active && !done && cyc_num != CNT_MAX) |=> (cyc_num == $past(cyc_num) + 1'b1));
    p_wait_flag_r10: assert property (@(posedge clk) disable iff (rst)
        (in_wait |-> (active && cyc_num > 1)));

endmodule

bind bws_seq bws_seq_chk #(.WC_W(WC_W), .CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .req     (req),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .cyc_num (cyc_num),
    .in_wait (in_wait),
    .done    (done),
    .wc_lat  (wc_lat)
);

// File: tb/bws_seq_test.sv
`timescale 1ns/1ps
module bws_seq_test;

    localparam int WC_W  = 3;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req = 1'b0;
    logic             req_write = 1'b0;
    logic [WC_W-1:0]  wait_cfg = '0;
    logic             ext_wait_n = 1'b1;
    logic             rd_n;
    logic             wr_n;
    logic [CNT_W-1:0] cyc_num;
    logic             in_wait;
    logic             done;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    bws_seq #(.WC_W(WC_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst(rst), .req(req), .req_write(req_write),
        .wait_cfg(wait_cfg), .ext_wait_n(ext_wait_n),
        .rd_n(rd_n), .wr_n(wr_n), .cyc_num(cyc_num),
        .in_wait(in_wait), .done(done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int prog_len(input bit wr, input int wc);
        if (wr) return (wc + 1 < 2) ? 2 : wc + 1;
        return wc + 1;
    endfunction

    function automatic int total_len(input bit wr, input int wc, input int hold);
        int p = prog_len(wr, wc);
        if (!wr) return p + hold;
        return (hold == 0) ? p : p + hold + 1;
    endfunction

    task automatic end_summary;
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog expired");
            end_summary();
        end
    end

    // One access; entered and left at posedge+1 with the sequencer idle.
    task automatic access(input bit wr, input int wc, input bit noise, input int hold);
        int p    = prog_len(wr, wc);
        int len  = total_len(wr, wc, hold);
        int base = wr ? 2 : 1;
        req        = 1'b1;
        req_write  = wr;
        wait_cfg   = WC_W'(wc);
        ext_wait_n = 1'($urandom % 2);
        @(posedge clk); #1;
        for (int k = 1; k <= len + 1; k++) begin
            if (k < p)              ext_wait_n = noise ? 1'($urandom % 2) : 1'b1;
            else if (k < p + hold)  ext_wait_n = 1'b0;
            else if (k == p + hold) ext_wait_n = 1'b1;
            else                    ext_wait_n = 1'($urandom % 2);
            if (k <= len) begin
                // R9: inputs scrambled in mid-access
                req       = 1'($urandom % 2);
                req_write = 1'($urandom % 2);
                wait_cfg  = WC_W'($urandom);
            end else begin
                req = 1'b0;
            end
            @(negedge clk);
            if (k <= len) begin
                chk(wr ? "R3/R5 done timing" : "R2/R4 done timing", int'(done), int'(k == len));
                chk("R8 rd_n", int'(rd_n), int'(wr));
                chk("R8 wr_n", int'(wr_n), int'(!wr));
                chk("R10 cyc_num", int'(cyc_num), k);
                chk("R10 in_wait", int'(in_wait), int'(k > base));
            end else begin
                chk("R7 done idle", int'(done), 0);
                chk("R8 strobes released", int'(rd_n && wr_n), 1);
                chk("R9 no extra access", int'(cyc_num), 0);
            end
            @(posedge clk); #1;
        end
    endtask

    initial begin
        $urandom(32'h5eed_b005);
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        chk("R1 rd_n reset", int'(rd_n), 1);
        chk("R1 wr_n reset", int'(wr_n), 1);
        chk("R1 done reset", int'(done), 0);
        chk("R1 cyc_num reset", int'(cyc_num), 0);
        chk("R1 in_wait reset", int'(in_wait), 0);
        @(posedge clk); #1;
        rst = 1'b0;
        @(posedge clk); #1;

        // R2 / R3: every programmed setting, no external wait
        for (int w = 0; w < 8; w++) access(1'b0, w, 1'b0, 0);
        for (int w = 0; w < 8; w++) access(1'b1, w, 1'b0, 0);
        // R3: one programmed wait on a write is absorbed
        access(1'b1, 1, 1'b0, 0);
        // R4 / R5: external stretching
        access(1'b0, 0, 1'b0, 1);
        access(1'b0, 3, 1'b0, 4);
        access(1'b1, 0, 1'b0, 1);
        access(1'b1, 1, 1'b0, 2);
        access(1'b1, 5, 1'b0, 3);
        // R6: wait-pin noise before the programmed end
        access(1'b0, 7, 1'b1, 0);
        access(1'b1, 7, 1'b1, 2);

        for (int i = 0; i < 300; i++) begin
            bit wr = 1'($urandom % 2);
            int wc = int'($urandom % 8);
            int hd = ($urandom % 3 == 0) ? int'($urandom % 6) : 0;
            int gap = int'($urandom % 3);
            access(wr, wc, 1'($urandom % 2), hd);
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                chk("R7 idle gap", int'(done), 0);
                @(posedge clk); #1;
            end
        end

        // R1: reset in mid-access returns to idle
        req = 1'b1; req_write = 1'b0; wait_cfg = 3'd7; ext_wait_n = 1'b1;
        @(posedge clk); #1;
        req = 1'b0; rst = 1'b1;
        @(posedge clk); #1;
        @(negedge clk);
        chk("R1 mid-access reset strobes", int'(rd_n && wr_n), 1);
        chk("R1 mid-access reset count", int'(cyc_num), 0);
        @(posedge clk); #1;
        rst = 1'b0;
        @(posedge clk); #1;
        end_summary();
    end

endmodule